// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block holds the per-source state of a small multi-processor interrupt controller. The number of sources is a multiple of 32, and the number of processors is from 1 to 8. For each source it stores an enable bit, one pending bit per processor, a priority byte, a target processor mask, two configuration bits and the last sampled input level. The first 32 sources are private to each processor. The other sources are driven by external level lines, one line per source.

Software uses a single word-wide register port with byte strobes. Each access carries the number of the processor that issues it. Enables and pending bits have separate set windows and clear windows, and in each of them a 1 bit performs the action. A software-trigger register makes one of the first 16 private sources pending on a filtered set of processors. The block drives out its global enable, the enable and pending vectors, and one priority byte per processor and source. The per-processor interfaces use these outputs to pick the interrupt to signal. Writes take effect at the next rising clock edge. Read data is combinational from the current state, and a read has no side effects.

Top module: `irq_distributor`

## Requirements
- R1: After reset all enables, pending bits, levels, configuration bits, priorities, targets and the global enable are 0.
- R2: Address 0x000 bit 0 is the global enable and reads back as written. Address 0x004 reads (sources/32 − 1) in bits [4:0] and (processors − 1) in bits [7:5].
- R3: Words from 0x100 set enables and words from 0x180 clear them. In these windows word w bit b addresses source 32·w+b. Only 1 bits in lanes whose strobe is set act, and either window reads back the enable bits.
- R4: Bytes from 0x400 hold one priority per source, and byte n is source n. Each processor has its own copy for sources 0–31. Shared sources have one copy.
- R5: Bytes from 0x800 hold the target mask of each shared source. Only the low (processors) bits are stored. Writes to the target bytes of private sources are ignored. Reading them returns the reader's own one-hot bit for sources 29–31 and 0 for the others.
- R6: Words from 0xC00 hold two bits per source, with source n at bits [2(n mod 16)+1 : 2(n mod 16)] of word n/16. Bit 0 selects the 1-of-N model and bit 1 selects edge triggering. Both bits read back as written.
- R7: A low-to-high change on the line of a shared source makes it pending on its target processors if the source is edge-triggered or enabled. A line that stays high adds nothing, and a line that rises while the source is neither enabled nor edge-triggered sets nothing.
- R8: Setting the enable of a level-triggered shared source whose line is high makes it pending on its target processors.
- R9: Words from 0x200 set pending bits, on the targets for shared sources and on the writer only for private sources. Words from 0x280 clear the pending bit for all processors at once. A read returns the reader's own bit for private sources and the OR over all processors for shared sources.
- R10: A write to 0xF00 with all four strobes set makes private source wdata[3:0] pending. Bits [25:24] select the processors: 0 selects the list in bits [23:16], 1 selects all except the writer, 2 selects the writer only, and 3 selects none. A write with any strobe clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_cpu | input | CW | Number of the processor issuing the access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr as seen by bus_cpu |
| irq_lines | input | NUM_SRC-32 | Level input of each shared source; bit i is source 32+i |
| dist_on | output | 1 | Global enable |
| src_enable | output | NUM_SRC | Enable bit of each source |
| src_pending | output | NUM_CPU*NUM_SRC | Pending bits; bit c*NUM_SRC+n is source n on processor c |
| src_priority | output | NUM_CPU*NUM_SRC*8 | Priority byte at (c*NUM_SRC+n)*8 as seen by processor c |

## Verification
The assertions check four behaviours on every cycle. The state is clear in the first cycle after reset. The global enable follows its write on the next cycle. A clear-enable write removes the enable. A software-trigger write either leaves the private pending bits untouched (reserved filter) or sets the writer's bit (self filter). The bench scenarios cover the rest. These are the level and edge pending rules, the interaction of a rising line with enable and configuration, the separate private priority copies per processor, the masking of targets and the read-back of private targets, the clearing of a pending bit across all processors, and the processor-list and all-but-writer filters.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned PRIV_SRCS = 32;
  localparam int unsigned SGI_SRCS  = 16;

  // Decoded with bus_addr[11:7]
  localparam logic [4:0] WIN_EN_SET = 5'h02;
  localparam logic [4:0] WIN_EN_CLR = 5'h03;
  localparam logic [4:0] WIN_PD_SET = 5'h04;
  localparam logic [4:0] WIN_PD_CLR = 5'h05;

  // Decoded with bus_addr[11:10]
  localparam logic [1:0] WIN_PRIO = 2'd1;
  localparam logic [1:0] WIN_TGT  = 2'd2;
  localparam logic [1:0] WIN_CFG  = 2'd3;

  localparam logic [11:0] ADDR_CTRL = 12'h000;
  localparam logic [11:0] ADDR_TYPE = 12'h004;
  localparam logic [11:0] ADDR_SGI  = 12'hF00;

  typedef enum logic [1:0] {
    SGI_LIST   = 2'd0,
    SGI_OTHERS = 2'd1,
    SGI_SELF   = 2'd2,
    SGI_NONE   = 2'd3
  } sgi_filter_e;
endpackage

// File: rtl/irqd_src_cell.sv
module irqd_src_cell #(
  parameter int unsigned NUM_CPU = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_i,
  input  logic [NUM_CPU-1:0] pend_set_i,
  input  logic               pend_clr_i,
  input  logic [NUM_CPU-1:0] tgt_i,
  output logic               en_o,
  output logic [NUM_CPU-1:0] pend_o,
  output logic [1:0]         cfg_o
);
  logic               en_q, en_d, lvl_q, rise;
  logic [1:0]         cfg_q;
  logic [NUM_CPU-1:0] pend_q, pend_d, hw_set;

  always_comb begin
    rise   = line_i & ~lvl_q;
    en_d   = (en_q | en_set_i) & ~en_clr_i;
    hw_set = '0;
    if (rise && (cfg_q[1] || en_q)) hw_set = tgt_i;
    if (en_set_i && line_i && !cfg_q[1]) hw_set = hw_set | tgt_i;
    // sets win over a clear in the same cycle
    pend_d = (pend_q & ~{NUM_CPU{pend_clr_i}}) | pend_set_i | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cfg_q  <= 2'b00;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      lvl_q  <= line_i;
      pend_q <= pend_d;
      if (cfg_we_i) cfg_q <= cfg_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/irqd_byte_bank.sv
module irqd_byte_bank #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_prio_i,
  input  logic                         we_tgt_i,
  input  logic [7:0]                   word_i,
  input  logic [3:0]                   be_i,
  input  logic [31:0]                  wdata_i,
  input  logic [CW-1:0]                cpu_i,
  output logic [NUM_CPU*NUM_SRC*8-1:0] prio_o,
  output logic [NUM_SRC*NUM_CPU-1:0]   tgt_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam logic [7:0] WSEL = 8'(s / 4);
    localparam int unsigned LANE = s % 4;
    logic hit;
    assign hit = (word_i == WSEL) && be_i[LANE];

    if (s < irqd_pkg::PRIV_SRCS) begin : g_priv
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [7:0] p_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) p_q <= 8'h00;
          else if (we_prio_i && hit && (int'(cpu_i) == c)) p_q <= wdata_i[LANE*8 +: 8];
        end
        assign prio_o[(c*NUM_SRC+s)*8 +: 8] = p_q;
      end
      assign tgt_o[s*NUM_CPU +: NUM_CPU] = '0;
    end else begin : g_shr
      logic [7:0]         p_q;
      logic [NUM_CPU-1:0] t_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_q <= 8'h00;
          t_q <= '0;
        end else begin
          if (we_prio_i && hit) p_q <= wdata_i[LANE*8 +: 8];
          if (we_tgt_i && hit)  t_q <= wdata_i[LANE*8 +: NUM_CPU];
        end
      end
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign prio_o[(c*NUM_SRC+s)*8 +: 8] = p_q;
      end
      assign tgt_o[s*NUM_CPU +: NUM_CPU] = t_q;
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned CW  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned EXT = NUM_SRC - 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CW-1:0]                bus_cpu,
  input  logic                         bus_we,
  input  logic [11:0]                  bus_addr,
  input  logic [3:0]                   bus_be,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [EXT-1:0]               irq_lines,
  output logic                         dist_on,
  output logic [NUM_SRC-1:0]           src_enable,
  output logic [NUM_CPU*NUM_SRC-1:0]   src_pending,
  output logic [NUM_CPU*NUM_SRC*8-1:0] src_priority
);
  import irqd_pkg::*;

  localparam int unsigned NS = NUM_SRC;
  localparam int unsigned NC = NUM_CPU;
  localparam logic [31:0] TYPE_VAL = 32'((NS / 32) - 1) | (32'(NC - 1) << 5);

  logic [4:0]  win7;
  logic [1:0]  win10;
  logic [4:0]  wsel;
  logic [7:0]  bword;
  logic        cfg_hit, sgi_hit, dist_q, dist_d;
  logic [NC-1:0] cpu_1h, sgi_mask;
  logic [NS-1:0] en_set, en_clr, pd_set, pd_clr, cfg_we, line_vec, pend_rd;
  logic [1:0]    cfg_val [NS];
  logic [1:0]    cfg_q   [NS];
  logic [NC-1:0] pset    [NS];
  logic [NC-1:0] pend_q  [NS];
  logic [NS*NC-1:0] tgt_flat;

  assign win7  = bus_addr[11:7];
  assign win10 = bus_addr[11:10];
  assign wsel  = bus_addr[6:2];
  assign bword = bus_addr[9:2];
  assign cfg_hit = bus_we && (win10 == WIN_CFG) && (bus_addr < ADDR_SGI);
  assign sgi_hit = bus_we && (bus_addr == ADDR_SGI) && (&bus_be);
  assign cpu_1h  = NC'(1) << bus_cpu;
  assign line_vec = {irq_lines, 32'b0};

  // Software-trigger processor filter
  always_comb begin
    case (sgi_filter_e'(bus_wdata[25:24]))
      SGI_LIST:   sgi_mask = bus_wdata[16 +: NC];
      SGI_OTHERS: sgi_mask = ~cpu_1h;
      SGI_SELF:   sgi_mask = cpu_1h;
      default:    sgi_mask = '0;
    endcase
  end

  // Per-source write decode
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      en_set[s] = bus_we && (win7 == WIN_EN_SET) && (int'(wsel) == s/32) && bus_be[(s%32)/8] && bus_wdata[s%32];
      en_clr[s] = bus_we && (win7 == WIN_EN_CLR) && (int'(wsel) == s/32) && bus_be[(s%32)/8] && bus_wdata[s%32];
      pd_set[s] = bus_we && (win7 == WIN_PD_SET) && (int'(wsel) == s/32) && bus_be[(s%32)/8] && bus_wdata[s%32];
      pd_clr[s] = bus_we && (win7 == WIN_PD_CLR) && (int'(wsel) == s/32) && bus_be[(s%32)/8] && bus_wdata[s%32];
      cfg_we[s] = cfg_hit && (int'(bword) == s/16) && bus_be[(s%16)/4];
      cfg_val[s] = bus_wdata[2*(s%16) +: 2];
      pset[s] = '0;
      if (pd_set[s]) pset[s] = (s < 32) ? cpu_1h : tgt_flat[s*NC +: NC];
      if (s < 16 && sgi_hit && (int'(bus_wdata[3:0]) == s)) pset[s] = pset[s] | sgi_mask;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_cell
    irqd_src_cell #(.NUM_CPU(NC)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_vec[s]),
      .en_set_i   (en_set[s]),
      .en_clr_i   (en_clr[s]),
      .cfg_we_i   (cfg_we[s]),
      .cfg_i      (cfg_val[s]),
      .pend_set_i (pset[s]),
      .pend_clr_i (pd_clr[s]),
      .tgt_i      ((s < 32) ? {NC{1'b0}} : tgt_flat[s*NC +: NC]),
      .en_o       (src_enable[s]),
      .pend_o     (pend_q[s]),
      .cfg_o      (cfg_q[s])
    );
    for (genvar c = 0; c < NC; c++) begin : g_pcpu
      assign src_pending[c*NS + s] = pend_q[s][c];
    end
  end

  irqd_byte_bank #(.NUM_SRC(NS), .NUM_CPU(NC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_prio_i (bus_we && (win10 == WIN_PRIO)),
    .we_tgt_i  (bus_we && (win10 == WIN_TGT)),
    .word_i    (bword),
    .be_i      (bus_be),
    .wdata_i   (bus_wdata),
    .cpu_i     (bus_cpu),
    .prio_o    (src_priority),
    .tgt_o     (tgt_flat)
  );

  // Global enable: next state and register
  assign dist_d = (bus_we && (bus_addr == ADDR_CTRL) && bus_be[0]) ? bus_wdata[0] : dist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= 1'b0;
    else        dist_q <= dist_d;
  end
  assign dist_on = dist_q;

  // Pending as seen by the reader
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      pend_rd[s] = (s < 32) ? pend_q[s][bus_cpu] : (|pend_q[s]);
    end
  end

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) begin
      bus_rdata[0] = dist_q;
    end else if (bus_addr == ADDR_TYPE) begin
      bus_rdata = TYPE_VAL;
    end else if (win7 == WIN_EN_SET || win7 == WIN_EN_CLR) begin
      for (int b = 0; b < 32; b++)
        if (int'(wsel)*32 + b < NS) bus_rdata[b] = src_enable[int'(wsel)*32 + b];
    end else if (win7 == WIN_PD_SET || win7 == WIN_PD_CLR) begin
      for (int b = 0; b < 32; b++)
        if (int'(wsel)*32 + b < NS) bus_rdata[b] = pend_rd[int'(wsel)*32 + b];
    end else if (win10 == WIN_PRIO) begin
      for (int l = 0; l < 4; l++)
        if (int'(bword)*4 + l < NS)
          bus_rdata[l*8 +: 8] = src_priority[(int'(bus_cpu)*NS + int'(bword)*4 + l)*8 +: 8];
    end else if (win10 == WIN_TGT) begin
      for (int l = 0; l < 4; l++) begin
        if (int'(bword)*4 + l < 32) begin
          if (int'(bword)*4 + l >= 29) bus_rdata[l*8 +: NC] = cpu_1h;
        end else if (int'(bword)*4 + l < NS) begin
          bus_rdata[l*8 +: NC] = tgt_flat[(int'(bword)*4 + l)*NC +: NC];
        end
      end
    end else if (bus_addr < ADDR_SGI) begin
      for (int k = 0; k < 16; k++)
        if (int'(bword)*16 + k < NS) bus_rdata[2*k +: 2] = cfg_q[int'(bword)*16 + k];
    end
  end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CW-1:0]              bus_cpu,
  input logic                       bus_we,
  input logic [11:0]                bus_addr,
  input logic [3:0]                 bus_be,
  input logic [31:0]                bus_wdata,
  input logic                       dist_on,
  input logic [NUM_SRC-1:0]         src_enable,
  input logic [NUM_CPU*NUM_SRC-1:0] src_pending
);
  logic              seen_q, self_q, sgi_wr;
  logic [31:0]       idx_q;
  logic [NUM_CPU*16-1:0] sgi_bits;

  assign sgi_wr = bus_we && (bus_addr == 12'hF00) && (&bus_be);

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++)
      for (int k = 0; k < 16; k++)
        sgi_bits[c*16 + k] = src_pending[c*NUM_SRC + k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      self_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      seen_q <= 1'b1;
      self_q <= sgi_wr && (bus_wdata[25:24] == 2'd2);
      idx_q  <= 32'(int'(bus_cpu)*NUM_SRC + int'(bus_wdata[3:0]));
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!dist_on && src_enable == '0 && src_pending == '0));

  p_ctrl_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h000 && bus_be[0]) |=> (dist_on == $past(bus_wdata[0])));

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 12'h180 && bus_be[0] && bus_wdata[0]) |=> !src_enable[0]);

  p_sgi_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_wr && bus_wdata[25:24] == 2'd3) |=> $stable(sgi_bits));

  p_sgi_self_r10: assert property (@(posedge clk) disable iff (!rst_n)
    self_q |-> src_pending[idx_q]);
endmodule

bind irq_distributor irqd_checker #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .dist_on(dist_on), .src_enable(src_enable),
  .src_pending(src_pending)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int NS = 64;
  localparam int NC = 2;

  logic        clk, rst_n, bus_we;
  logic [0:0]  bus_cpu;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NS-33:0] irq_lines;
  logic        dist_on;
  logic [NS-1:0]      src_enable;
  logic [NC*NS-1:0]   src_pending;
  logic [NC*NS*8-1:0] src_priority;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irq_distributor #(.NUM_SRC(NS), .NUM_CPU(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .dist_on(dist_on), .src_enable(src_enable), .src_pending(src_pending),
    .src_priority(src_priority)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] data;   // write data, or expected read data
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd2,  12'h004, 4'hF, 32'h0000_0021},  // R2 type word
    '{1'b1, 4'd2,  12'h000, 4'h1, 32'h0000_0001},
    '{1'b0, 4'd2,  12'h000, 4'hF, 32'h0000_0001},  // R2 enable readback
    '{1'b1, 4'd3,  12'h100, 4'hF, 32'h0000_00F0},
    '{1'b1, 4'd3,  12'h104, 4'hF, 32'h8000_0001},
    '{1'b0, 4'd3,  12'h100, 4'hF, 32'h0000_00F0},  // R3
    '{1'b1, 4'd3,  12'h180, 4'hF, 32'h0000_0030},
    '{1'b0, 4'd3,  12'h180, 4'hF, 32'h0000_00C0},  // R3 clear
    '{1'b1, 4'd3,  12'h184, 4'h7, 32'h8000_0000},
    '{1'b0, 4'd3,  12'h104, 4'hF, 32'h8000_0001},  // R3 strobe off
    '{1'b1, 4'd4,  12'h420, 4'hF, 32'h4433_2211},
    '{1'b0, 4'd4,  12'h420, 4'hF, 32'h4433_2211},  // R4
    '{1'b1, 4'd4,  12'h400, 4'h5, 32'hAABB_CCDD},
    '{1'b0, 4'd4,  12'h400, 4'hF, 32'h00BB_00DD},  // R4 lanes
    '{1'b1, 4'd5,  12'h820, 4'hF, 32'hFF02_0101},
    '{1'b0, 4'd5,  12'h820, 4'hF, 32'h0302_0101},  // R5 masked
    '{1'b0, 4'd5,  12'h81C, 4'hF, 32'h0101_0100}   // R5 own bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = 1'(cpu); bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_cpu = 1'(cpu); bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic pb(input int c, input int s);
    return src_pending[c*NS + s];
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_cpu = '0; bus_addr = '0; bus_be = '0;
    bus_wdata = '0; irq_lines = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 dist_on", {31'b0, dist_on}, 32'h0);
    chk("R1 enables", {31'b0, |src_enable}, 32'h0);
    chk("R1 pending", {31'b0, |src_pending}, 32'h0);
    chk("R1 priority", {31'b0, |src_priority}, 32'h0);
    rd(0, 12'h820, r); chk("R1 target", r, 32'h0);
    rd(0, 12'hC00, r); chk("R1 config", r, 32'h0);

    // Table walk, processor 0
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(0, VEC[i].addr, VEC[i].be, VEC[i].data);
      else begin
        rd(0, VEC[i].addr, r);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].data);
      end
    end

    // R6 configuration bits
    wr(0, 12'hC04, 4'hF, 32'h0000_000E);
    rd(0, 12'hC04, r); chk("R6 cfg readback", r, 32'h0000_000E);

    // R4 private copies per processor
    wr(1, 12'h400, 4'hF, 32'h1111_1111);
    rd(0, 12'h400, r); chk("R4 cpu0 copy", r, 32'h00BB_00DD);
    rd(1, 12'h400, r); chk("R4 cpu1 copy", r, 32'h1111_1111);
    chk("R4 priority port", {24'b0, src_priority[(1*NS+0)*8 +: 8]}, 32'h11);

    // R5 private target writes ignored
    wr(0, 12'h800, 4'hF, 32'hFFFF_FFFF);
    rd(0, 12'h800, r); chk("R5 private target", r, 32'h0);
    rd(1, 12'h81C, r); chk("R5 cpu1 own bit", r, 32'h0202_0200);

    // R7 rising line on enabled level source 32 (target cpu0)
    @(negedge clk) irq_lines[0] = 1'b1;
    @(negedge clk);
    chk("R7 enabled rise", {30'b0, pb(1,32), pb(0,32)}, 32'h1);
    wr(0, 12'h284, 4'hF, 32'h0000_0001);
    repeat (2) @(negedge clk);
    chk("R7 held high", {31'b0, pb(0,32)}, 32'h0);

    // R7 rise on disabled level source 33: nothing
    @(negedge clk) irq_lines[1] = 1'b1;
    @(negedge clk);
    chk("R7 disabled rise", {30'b0, pb(1,33), pb(0,33)}, 32'h0);

    // R8 enable while line high
    wr(0, 12'h104, 4'hF, 32'h0000_0002);
    chk("R8 enable level high", {30'b0, pb(1,33), pb(0,33)}, 32'h1);

    // R7 edge source 34 (target cpu1), not enabled
    wr(0, 12'hC08, 4'hF, 32'h0000_0020);
    rd(0, 12'hC08, r); chk("R6 edge bit", r, 32'h0000_0020);
    @(negedge clk) irq_lines[2] = 1'b1;
    @(negedge clk);
    chk("R7 edge rise", {30'b0, pb(1,34), pb(0,34)}, 32'h2);
    rd(0, 12'h204, r); chk("R9 shared OR read", r, 32'h0000_0006);

    // R9 set/clear pending
    wr(0, 12'h204, 4'hF, 32'h0000_0008);
    chk("R9 set on targets", {30'b0, pb(1,35), pb(0,35)}, 32'h3);
    wr(1, 12'h200, 4'hF, 32'h0000_0100);
    chk("R9 private writer only", {30'b0, pb(1,8), pb(0,8)}, 32'h2);
    rd(0, 12'h200, r); chk("R9 private own read", r, 32'h0);
    wr(0, 12'h284, 4'hF, 32'hFFFF_FFFF);
    chk("R9 clear all cpus", {30'b0, |src_pending[2*NS-1:NS+32], |src_pending[NS-1:32]}, 32'h0);
    wr(0, 12'h280, 4'hF, 32'h0000_0100);
    chk("R9 private clear", {31'b0, pb(1,8)}, 32'h0);

    // R10 software trigger filters
    wr(0, 12'hF00, 4'hF, 32'h0002_0005);
    chk("R10 list", {30'b0, pb(1,5), pb(0,5)}, 32'h2);
    wr(0, 12'hF00, 4'hF, 32'h0100_0006);
    chk("R10 others", {30'b0, pb(1,6), pb(0,6)}, 32'h2);
    wr(1, 12'hF00, 4'hF, 32'h0200_0007);
    chk("R10 self", {30'b0, pb(1,7), pb(0,7)}, 32'h2);
    wr(0, 12'hF00, 4'hF, 32'h0300_0009);
    chk("R10 reserved", {30'b0, pb(1,9), pb(0,9)}, 32'h0);
    wr(0, 12'hF00, 4'h7, 32'h0200_000A);
    chk("R10 partial strobe", {30'b0, pb(1,10), pb(0,10)}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule